// File: doc/BRIEF.md
# Aliased-Address Register Access Bridge

This bridge is a bus slave placed in front of a small bank of 32-bit target registers. Each register can be reached through several address windows. Each window gives a different write operation on the same storage:
- plain replacement of the addressed bytes;
- setting of marked bits;
- clearing of marked bits;
- masked writes, in which one bus write carries both a field mask and field data for a nibble, a byte or a halfword.

Every write is applied as a read-modify-write of the selected register within a single clock edge. No other access can slip between the read and the write, so software can change single bits of a shared register without a lock.

The bus side accepts byte, halfword and word requests through a valid/ready handshake. Every accepted request gets exactly one response on the following cycle, carrying read data or an error flag. Reads are served only through the plain window. The current contents of all registers are brought out on a flat vector so the functions the registers control can use them.

Top module: `alias_reg_bridge`

## Requirements
- R1: While reset is asserted and immediately after it, every register reads as zero on `regs_o` and `rsp_valid` is low.
- R2: `req_ready` is always high, and every cycle with `req_valid` high is followed on the next cycle by exactly one cycle of `rsp_valid`. No response appears otherwise.
- R3: Window map by address: plain at 0x000, set at 0x040, clear at 0x080, nibble-masked at 0x100, byte-masked at 0x180, halfword-masked at 0x200, each window 64 (first three) or 128 bytes (masked ones) long. The register index is addr[5:2] in the first three windows and addr[6:3] in the masked windows.
- R4: In the plain window a write replaces only the addressed bytes. `req_size` encodes 0 = byte, 1 = halfword, 2 = word. The first byte lane is addr[1:0], and the operand is taken right-justified from `req_wdata`.
- R5: In the set window, each 1 in the right-justified operand, placed at the addressed lanes, forces the matching register bit to 1. All other bits keep their value.
- R6: In the clear window, each 1 in the right-justified operand, placed at the addressed lanes, forces the matching register bit to 0. All other bits keep their value.
- R7: In the nibble-masked window (byte access only), wdata[7:4] is the mask and wdata[3:0] is the data. Nibble addr[2:0] is written, and only where the mask bit is 1.
- R8: In the byte-masked window (halfword access only), wdata[15:8] is the mask and wdata[7:0] is the data. Offset addr[2:0] = 2·k selects byte k.
- R9: In the halfword-masked window (word access only), wdata[31:16] is the mask and wdata[15:0] is the data. Offset 0 selects bits 15:0 and offset 4 selects bits 31:16.
- R10: A byte or halfword read in the plain window returns the addressed lanes right-justified and zero-extended in `rsp_rdata`, and leaves every register unchanged. A successful write returns zero data.
- R11: The following complete with `rsp_err` high, `rsp_rdata` zero and all registers unchanged:
  - a masked access of the wrong size, or a byte-masked access at an odd offset;
  - a read outside the plain window, or a word read;
  - a halfword access at an odd address or a word access at an unaligned address;
  - an address outside all windows;
  - a register index ≥ `NUM_REGS`;
  - size code 3.
- R12: Writes take effect at the edge that produces their response. A request accepted on the very next cycle already operates on the updated value, and idle cycles leave the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | ADDR_W | Byte address inside the bridge space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write operand, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, right-justified |
| regs_o | output | 32·NUM_REGS | Register contents, register i at bits 32·i+31:32·i |

## Verification
The assertions assume that the request inputs hold defined values in every cycle after reset is released, and that reset is low from time zero until after the first edges. The set-only-raises and clear-only-lowers properties depend on the address being stable across the sampling edge. The stimulus drives every request field on falling edges only, keeps all fields at known values while idle, and holds reset for several cycles before the first request.

// File: rtl/alias_bridge_pkg.sv
package alias_bridge_pkg;

    localparam int DATA_W      = 32;
    localparam int SLOT_W      = 4;     // index bits available inside one window
    localparam int BASE_SET    = 'h040;
    localparam int BASE_CLR    = 'h080;
    localparam int WORD_SPAN   = 'h040;
    localparam int BASE_NIB    = 'h100;
    localparam int BASE_BYTE   = 'h180;
    localparam int BASE_HALF   = 'h200;
    localparam int FIELD_SPAN  = 'h080;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        WIN_DIRECT,
        WIN_SET,
        WIN_CLEAR,
        WIN_NIB,
        WIN_BYTE,
        WIN_HALF,
        WIN_NONE
    } win_e;

endpackage

// File: rtl/alias_win_decode.sv
module alias_win_decode
    import alias_bridge_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  acc_size_e         size,
    output win_e              win,
    output logic [SLOT_W-1:0] slot,
    output logic [2:0]        off,
    output logic              err
);

    logic bad_shape;
    logic bad_slot;
    logic bad_read;

    // window and index selection
    always_comb begin
        win  = WIN_NONE;
        slot = '0;
        off  = '0;
        if (addr < ADDR_W'(BASE_SET)) begin
            win  = WIN_DIRECT;
            slot = addr[5:2];
            off  = {1'b0, addr[1:0]};
        end else if (addr < ADDR_W'(BASE_CLR)) begin
            win  = WIN_SET;
            slot = addr[5:2];
            off  = {1'b0, addr[1:0]};
        end else if (addr < ADDR_W'(BASE_CLR + WORD_SPAN)) begin
            win  = WIN_CLEAR;
            slot = addr[5:2];
            off  = {1'b0, addr[1:0]};
        end else if (addr < ADDR_W'(BASE_NIB)) begin
            win  = WIN_NONE;
        end else if (addr < ADDR_W'(BASE_BYTE)) begin
            win  = WIN_NIB;
            slot = addr[6:3];
            off  = addr[2:0];
        end else if (addr < ADDR_W'(BASE_HALF)) begin
            win  = WIN_BYTE;
            slot = addr[6:3];
            off  = addr[2:0];
        end else if (addr < ADDR_W'(BASE_HALF + FIELD_SPAN)) begin
            win  = WIN_HALF;
            slot = addr[6:3];
            off  = addr[2:0];
        end
    end

    // legality of the access shape per window
    always_comb begin
        case (win)
            WIN_DIRECT, WIN_SET, WIN_CLEAR:
                bad_shape = (size == SZ_HALF && off[0]) ||
                            (size == SZ_WORD && off[1:0] != 2'b00);
            WIN_NIB:  bad_shape = (size != SZ_BYTE);
            WIN_BYTE: bad_shape = (size != SZ_HALF) || off[0];
            WIN_HALF: bad_shape = (size != SZ_WORD) || (off[1:0] != 2'b00);
            default:  bad_shape = 1'b1;
        endcase
        bad_slot = ({1'b0, slot} >= (SLOT_W+1)'(NUM_REGS));
        bad_read = !write && (win != WIN_DIRECT || size == SZ_WORD);
        err      = bad_shape || bad_slot || bad_read || (size == SZ_BAD);
    end

endmodule

// File: rtl/alias_rmw_merge.sv
module alias_rmw_merge
    import alias_bridge_pkg::*;
(
    input  logic [DATA_W-1:0] old_val,
    input  win_e              win,
    input  acc_size_e         size,
    input  logic [2:0]        off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] rd_val
);

    logic [DATA_W-1:0] size_mask;
    logic [4:0]        lane_sh;
    logic [DATA_W-1:0] lane_opnd;
    logic [DATA_W-1:0] lane_mask;
    logic [4:0]        fld_sh;
    logic [DATA_W-1:0] fld_mask;
    logic [DATA_W-1:0] fld_data;

    always_comb begin
        case (size)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
        lane_sh   = {off[1:0], 3'b000};
        lane_opnd = (wdata & size_mask) << lane_sh;
        lane_mask = size_mask << lane_sh;

        // mask and data halves of the packed operand, moved to the field
        case (win)
            WIN_NIB: begin
                fld_sh   = {off, 2'b00};
                fld_mask = {28'b0, wdata[7:4]} << fld_sh;
                fld_data = {28'b0, wdata[3:0]} << fld_sh;
            end
            WIN_BYTE: begin
                fld_sh   = {off[2:1], 3'b000};
                fld_mask = {24'b0, wdata[15:8]} << fld_sh;
                fld_data = {24'b0, wdata[7:0]} << fld_sh;
            end
            default: begin
                fld_sh   = {off[2], 4'b0000};
                fld_mask = {16'b0, wdata[31:16]} << fld_sh;
                fld_data = {16'b0, wdata[15:0]} << fld_sh;
            end
        endcase

        case (win)
            WIN_DIRECT:                 new_val = (old_val & ~lane_mask) | lane_opnd;
            WIN_SET:                    new_val = old_val | lane_opnd;
            WIN_CLEAR:                  new_val = old_val & ~lane_opnd;
            WIN_NIB, WIN_BYTE, WIN_HALF: new_val = (old_val & ~fld_mask) | (fld_data & fld_mask);
            default:                    new_val = old_val;
        endcase

        rd_val = (old_val >> lane_sh) & size_mask;
    end

endmodule

// File: rtl/alias_reg_bridge.sv
module alias_reg_bridge
    import alias_bridge_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_write,
    input  logic [1:0]                 req_size,
    input  logic [31:0]                req_wdata,
    output logic                       rsp_valid,
    output logic                       rsp_err,
    output logic [31:0]                rsp_rdata,
    output logic [32*NUM_REGS-1:0]     regs_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            rsp_valid;
        logic                            rsp_err;
        logic [DATA_W-1:0]               rsp_rdata;
    } state_t;

    state_t state_d, state_q;

    win_e              dec_win;
    logic [SLOT_W-1:0] dec_slot;
    logic [2:0]        dec_off;
    logic              dec_err;
    logic [DATA_W-1:0] sel_old;
    logic [DATA_W-1:0] mrg_new;
    logic [DATA_W-1:0] mrg_rd;

    alias_win_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) decode_i (
        .addr  (req_addr),
        .write (req_write),
        .size  (acc_size_e'(req_size)),
        .win   (dec_win),
        .slot  (dec_slot),
        .off   (dec_off),
        .err   (dec_err)
    );

    always_comb begin
        sel_old = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (dec_slot == SLOT_W'(i)) sel_old = state_q.regs[i];
        end
    end

    alias_rmw_merge merge_i (
        .old_val (sel_old),
        .win     (dec_win),
        .size    (acc_size_e'(req_size)),
        .off     (dec_off),
        .wdata   (req_wdata),
        .new_val (mrg_new),
        .rd_val  (mrg_rd)
    );

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = req_valid;
        state_d.rsp_err   = 1'b0;
        state_d.rsp_rdata = '0;
        if (req_valid) begin
            if (dec_err) begin
                state_d.rsp_err = 1'b1;
            end else if (req_write) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (dec_slot == SLOT_W'(i)) state_d.regs[i] = mrg_new;
                end
            end else begin
                state_d.rsp_rdata = mrg_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign req_ready = 1'b1;
    assign rsp_valid = state_q.rsp_valid;
    assign rsp_err   = state_q.rsp_err;
    assign rsp_rdata = state_q.rsp_rdata;
    assign regs_o    = state_q.regs;

endmodule

// File: rtl/alias_bridge_chk.sv
module alias_bridge_chk #(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [ADDR_W-1:0]      req_addr,
    input logic                   rsp_valid,
    input logic                   rsp_err,
    input logic [31:0]            rsp_rdata,
    input logic [32*NUM_REGS-1:0] regs_o
);

    logic in_set_win;
    logic in_clr_win;
    assign in_set_win = (req_addr >= ADDR_W'('h040)) && (req_addr < ADDR_W'('h080));
    assign in_clr_win = (req_addr >= ADDR_W'('h080)) && (req_addr < ADDR_W'('h0C0));

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_ERR_ONLY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R11
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_rdata == 32'h0); // R11
    AST_ERR_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> regs_o == $past(regs_o)); // R11
    AST_READ_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> $stable(regs_o)); // R10
    AST_IDLE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(regs_o)); // R12
    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && in_set_win |=> (regs_o & $past(regs_o)) == $past(regs_o)); // R5
    AST_CLEAR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && in_clr_win |=> (regs_o | $past(regs_o)) == $past(regs_o)); // R6

endmodule

bind alias_reg_bridge alias_bridge_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .regs_o    (regs_o)
);

// File: tb/alias_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module alias_reg_bridge_tb_top;

    localparam int ADDR_W   = 10;
    localparam int NUM_REGS = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_ready;
    logic [ADDR_W-1:0]      req_addr = '0;
    logic                   req_write = 1'b0;
    logic [1:0]             req_size = 2'd0;
    logic [31:0]            req_wdata = '0;
    logic                   rsp_valid;
    logic                   rsp_err;
    logic [31:0]            rsp_rdata;
    logic [32*NUM_REGS-1:0] regs_o;

    int checks = 0;
    int errors = 0;
    logic        got_err;
    logic [31:0] got_rdata;

    always #2.5 clk = ~clk;

    alias_reg_bridge #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .regs_o(regs_o)
    );

    function automatic logic [31:0] reg_at(input int i);
        return regs_o[32*i +: 32];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [9:0] a, input logic w, input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_size = sz; req_wdata = wd;
        chk("R2 ready", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 2'd0; req_wdata = '0;
        chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        got_err   = rsp_err;
        got_rdata = rsp_rdata;
    endtask

    task automatic wr_ok(input string tag, input logic [9:0] a, input logic [1:0] sz, input logic [31:0] wd);
        acc(a, 1'b1, sz, wd);
        chk({tag, " err"}, {31'b0, got_err}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 regs zero", {31'b0, regs_o == '0}, 32'd1);
        chk("R1 rsp_valid low", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_direct();
        wr_ok("R4", 10'h008, 2'd2, 32'h1234_5678);
        chk("R4 word", reg_at(2), 32'h1234_5678);
        wr_ok("R4", 10'h00B, 2'd0, 32'h0000_00AB);
        chk("R4 byte lane3", reg_at(2), 32'hAB34_5678);
        wr_ok("R4", 10'h008, 2'd1, 32'h0000_BEEF);
        chk("R4 half low", reg_at(2), 32'hAB34_BEEF);
        @(negedge clk);
        chk("R12 idle keeps", reg_at(2), 32'hAB34_BEEF);
    endtask

    task automatic t_read();
        acc(10'h00B, 1'b0, 2'd0, 32'hFFFF_FFFF);
        chk("R10 byte read err", {31'b0, got_err}, 32'd0);
        chk("R10 byte read", got_rdata, 32'h0000_00AB);
        acc(10'h00A, 1'b0, 2'd1, 32'h0);
        chk("R10 half read", got_rdata, 32'h0000_AB34);
        chk("R10 read keeps reg", reg_at(2), 32'hAB34_BEEF);
        acc(10'h004, 1'b1, 2'd2, 32'h0000_0000);
        chk("R10 write data zero", got_rdata, 32'h0);
    endtask

    task automatic t_set_clear();
        wr_ok("R5", 10'h044, 2'd2, 32'hAAAA_AAAA);
        chk("R5 set word", reg_at(1), 32'hAAAA_AAAA);
        wr_ok("R5", 10'h046, 2'd0, 32'h0000_0055);
        chk("R5 set byte lane2", reg_at(1), 32'hAAFF_AAAA);
        wr_ok("R6", 10'h084, 2'd2, 32'h00FF_0000);
        chk("R6 clear word", reg_at(1), 32'hAA00_AAAA);
        wr_ok("R6", 10'h086, 2'd1, 32'h0000_F000);
        chk("R6 clear half high", reg_at(1), 32'h0A00_AAAA);
    endtask

    task automatic t_nibble();
        wr_ok("R7", 10'h118, 2'd0, 32'h0000_00F7);
        chk("R7 nibble0", reg_at(3), 32'h0000_0007);
        wr_ok("R7", 10'h119, 2'd0, 32'h0000_00F4);
        chk("R7 nibble1", reg_at(3), 32'h0000_0047);
        wr_ok("R7", 10'h11F, 2'd0, 32'h0000_003F);
        chk("R7 nibble7 partial mask", reg_at(3), 32'h3000_0047);
    endtask

    task automatic t_byte_field();
        wr_ok("R8", 10'h1A2, 2'd1, 32'h0000_FF11);
        chk("R8 byte1", reg_at(4), 32'h0000_1100);
        wr_ok("R8", 10'h1A6, 2'd1, 32'h0000_FF33);
        chk("R8 byte3", reg_at(4), 32'h3300_1100);
        wr_ok("R8", 10'h1A0, 2'd1, 32'h0000_0FFF);
        chk("R8 byte0 partial mask", reg_at(4), 32'h3300_110F);
    endtask

    task automatic t_half_field();
        wr_ok("R9", 10'h228, 2'd2, 32'hFFFF_5555);
        chk("R9 low half", reg_at(5), 32'h0000_5555);
        wr_ok("R9", 10'h22C, 2'd2, 32'h01FF_01AA);
        chk("R9 high half partial", reg_at(5), 32'h01AA_5555);
    endtask

    task automatic t_index_map();
        wr_ok("R3", 10'h01C, 2'd2, 32'hCAFE_F00D);
        chk("R3 direct idx7", reg_at(7), 32'hCAFE_F00D);
        wr_ok("R3", 10'h238, 2'd2, 32'hFFFF_1234);
        chk("R3 masked idx7", reg_at(7), 32'hCAFE_1234);
        acc(10'h01E, 1'b0, 2'd1, 32'h0);
        chk("R3 read idx7", got_rdata, 32'h0000_CAFE);
        chk("R3 reg0 untouched", reg_at(0), 32'h0);
    endtask

    task automatic bad(input string tag, input logic [9:0] a, input logic w, input logic [1:0] sz, input logic [31:0] wd);
        logic [32*NUM_REGS-1:0] snap;
        snap = regs_o;
        acc(a, w, sz, wd);
        chk({tag, " err"}, {31'b0, got_err}, 32'd1);
        chk({tag, " rdata"}, got_rdata, 32'h0);
        chk({tag, " regs kept"}, {31'b0, regs_o == snap}, 32'd1);
    endtask

    task automatic t_errors();
        bad("R11 nibble as half", 10'h118, 1'b1, 2'd1, 32'h0000_FFFF);
        bad("R11 halfmask as byte", 10'h228, 1'b1, 2'd0, 32'h0000_00FF);
        bad("R11 bytemask odd", 10'h1A1, 1'b1, 2'd1, 32'h0000_FF00);
        bad("R11 read set win", 10'h044, 1'b0, 2'd0, 32'h0);
        bad("R11 word read", 10'h008, 1'b0, 2'd2, 32'h0);
        bad("R11 index 8", 10'h020, 1'b1, 2'd2, 32'hFFFF_FFFF);
        bad("R11 masked index 8", 10'h240, 1'b1, 2'd2, 32'hFFFF_FFFF);
        bad("R11 gap", 10'h0C0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        bad("R11 above", 10'h280, 1'b1, 2'd2, 32'hFFFF_FFFF);
        bad("R11 odd half", 10'h009, 1'b1, 2'd1, 32'hFFFF_FFFF);
        bad("R11 size3", 10'h008, 1'b1, 2'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2;
        req_addr = 10'h058; req_wdata = 32'h0000_000F;
        @(negedge clk);
        chk("R12 first rsp", {31'b0, rsp_valid && !rsp_err}, 32'd1);
        req_addr = 10'h098; req_wdata = 32'h0000_0003;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_size = 2'd0;
        chk("R12 second rsp", {31'b0, rsp_valid && !rsp_err}, 32'd1);
        chk("R12 chained rmw", reg_at(6), 32'h0000_000C);
        @(negedge clk);
        chk("R12 no extra rsp", {31'b0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_read();
        t_set_clear();
        t_nibble();
        t_byte_field();
        t_half_field();
        t_index_map();
        t_errors();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule